// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block is the front end that turns asynchronous request lines into latched interrupt flags for a CPU. It serves five primary request sources and a bank of wakeup sources. Source 0 comes from another on-chip block and is already synchronous. Sources 1 to 4 and every wakeup line come from pins, so each passes through a two-flop synchronizer. Every source has a programmable edge polarity, an enable bit and a sticky request flag. The selected edge sets the flag whether or not the source is enabled. The single CPU request output is asserted while any flag is set together with its enable.

Software reaches the registers over a simple synchronous byte bus with a 16-bit address. Read data is combinational while the read strobe is high. A flag can only be cleared, by writing 0 to its bit. The polarity bit of source 4 also selects the active edge of a separate A/D trigger input. That input produces a one-cycle trigger pulse for the converter.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the registers read: edge select (0xFFF2) 0xE0, enable A (0xFFF3) 0x00, enable B (0xFFF4) 0x00, request A (0xFFF6) 0x20, request B (0xFFF7) 0x00, wakeup flags (0xFFF9) 0x00, wakeup polarity (0xFF90) 0x00. The CPU request output is low.
- R2: Bit i (i = 0..4) of the edge select register picks the edge for source i: 0 for falling, 1 for rising. The selected edge sets bit i of request A, and the opposite edge sets nothing. Source 0 is sampled without a synchronizer. Sources 1 to 4 are synchronized by two flops.
- R3: Bits 7 to 5 of the edge select register always read 1 and ignore writes.
- R4: Writing 0 to a bit of request A or of the wakeup flag register clears that flag. Writing 1 leaves it unchanged. Bit 5 of request A always reads 1, and bits 7 and 6 read 0.
- R5: When an edge is detected in the same cycle that software writes 0 to the same flag, the flag remains 1.
- R6: A flag is set even when its enable is 0. The CPU request output is high exactly when some request A bit i has enable A bit i set, or some wakeup flag bit j has enable B bit j set.
- R7: Changing an edge select bit while the input is at a steady level does not set a flag.
- R8: The A/D trigger output gives one single-cycle pulse for each falling edge of the synchronized trigger input when edge select bit 4 is 0, or for each rising edge when that bit is 1. The other edge gives no pulse.
- R9: Bit j of the wakeup polarity register picks the edge for wakeup line j (0 for falling, 1 for rising). The selected edge sets bit j of the wakeup flag register.
- R10: Reads of unmapped addresses return 0x00 and writes to them change no register. Request B always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, 0 otherwise |
| src_in | input | 5 | Request sources. Bit 0 is the internal source and bits 4:1 are pins |
| wake_in | input | 8 | Wakeup request pins |
| adtrg_in | input | 1 | External A/D trigger pin |
| adtrg_o | output | 1 | One-cycle A/D trigger pulse |
| irq_o | output | 1 | Combined interrupt request to the CPU |

## Verification
The main edge function is tried with a table of polarity and level-transition patterns. These include all-falling, all-rising, mixed polarities, and transitions in the direction opposite to the selected edge. Together they separate a detector that honours the polarity bit per source from one that reacts to any change or uses one shared polarity. Directed cases then drive the synchronous source 0 in the same cycle as a clearing write, toggle polarity over a steady high level, and count trigger pulses on both edges of the A/D input. Bus accesses to reserved bits and unmapped addresses show that they do not alias onto real state.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int NSRC  = 5;
    localparam int NWAKE = 8;
    localparam int ADTRG_SRC = 4;

    localparam logic [15:0] A_EDGE  = 16'hFFF2;
    localparam logic [15:0] A_EN1   = 16'hFFF3;
    localparam logic [15:0] A_EN2   = 16'hFFF4;
    localparam logic [15:0] A_REQ1  = 16'hFFF6;
    localparam logic [15:0] A_REQ2  = 16'hFFF7;
    localparam logic [15:0] A_WREQ  = 16'hFFF9;
    localparam logic [15:0] A_WEDGE = 16'hFF90;

    localparam logic [7:0] EDGE_RSV = 8'hE0;
    localparam logic [7:0] REQ1_RSV = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_EDGE, SEL_EN1, SEL_EN2,
        SEL_REQ1, SEL_REQ2, SEL_WREQ, SEL_WEDGE
    } reg_sel_e;

    typedef struct packed {
        logic [NSRC-1:0]  pol;
        logic [NSRC-1:0]  en;
        logic [NWAKE-1:0] wpol;
        logic [NWAKE-1:0] wen;
    } cfg_t;

    function automatic reg_sel_e decode(input logic [15:0] a);
        reg_sel_e s;
        case (a)
            A_EDGE:  s = SEL_EDGE;
            A_EN1:   s = SEL_EN1;
            A_EN2:   s = SEL_EN2;
            A_REQ1:  s = SEL_REQ1;
            A_REQ2:  s = SEL_REQ2;
            A_WREQ:  s = SEL_WREQ;
            A_WEDGE: s = SEL_WEDGE;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // pol = 1: rising, pol = 0: falling
    function automatic logic edge_hit(input logic pol, input logic cur, input logic prev);
        return pol ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/extint_edge_det.sv
module extint_edge_det
    import extint_pkg::*;
#(
    parameter int N = 5,
    parameter logic [N-1:0] SYNC_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] hit_o
);

    logic [N-1:0] cur;
    logic [N-1:0] hist;
    logic [N-1:0] pol_q;
    logic [N-1:0] pol_chg;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (SYNC_MASK[i]) begin : g_sync
                logic [1:0] ff;
                always_ff @(posedge clk) begin
                    if (rst) ff <= '0;
                    else     ff <= {ff[0], raw_i[i]};
                end
                assign cur[i] = ff[1];
            end else begin : g_direct
                assign cur[i] = raw_i[i];
            end
        end
    endgenerate

    // history always follows the sampled level, so a polarity write reloads it
    always_ff @(posedge clk) begin
        hist <= cur;
        if (rst) pol_q <= '0;
        else     pol_q <= pol_i;
    end

    assign pol_chg = pol_i ^ pol_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit_o[i] = edge_hit(pol_i[i], cur[i], hist[i]) & ~pol_chg[i];
        end
    end

    // R2
    hit_chg_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o & ~(cur ^ $past(cur))) == '0);

endmodule

// File: rtl/extint_flags.sv
module extint_flags #(
    parameter int N = 5,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] kept;

    assign kept = clr_we_i ? (flags_o & wdata_i) : flags_o;

    always_ff @(posedge clk) begin
        if (rst) flags_o <= RST_VAL;
        else     flags_o <= set_i | kept;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R4
    no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_o & ~$past(flags_o) & ~$past(set_i)) == '0);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_wr,
    input  logic             bus_rd,
    output logic [7:0]       bus_rdata,
    input  logic [NSRC-1:0]  src_in,
    input  logic [NWAKE-1:0] wake_in,
    input  logic             adtrg_in,
    output logic             adtrg_o,
    output logic             irq_o
);

    localparam logic [NSRC-1:0] SRC_SYNC = {{(NSRC-1){1'b1}}, 1'b0};

    reg_sel_e         sel;
    cfg_t             cfg;
    logic [NSRC-1:0]  src_hit;
    logic [NWAKE-1:0] wk_hit;
    logic [NSRC-1:0]  req_flags;
    logic [NWAKE-1:0] wk_flags;
    logic [7:0]       rd_val;

    assign sel = decode(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_EDGE:  cfg.pol  <= bus_wdata[NSRC-1:0];
                SEL_EN1:   cfg.en   <= bus_wdata[NSRC-1:0];
                SEL_EN2:   cfg.wen  <= bus_wdata[NWAKE-1:0];
                SEL_WEDGE: cfg.wpol <= bus_wdata[NWAKE-1:0];
                default:   ;
            endcase
        end
    end

    extint_edge_det #(.N(NSRC), .SYNC_MASK(SRC_SYNC)) u_src_det (
        .clk   (clk),
        .rst   (rst),
        .raw_i (src_in),
        .pol_i (cfg.pol),
        .hit_o (src_hit)
    );

    extint_edge_det #(.N(NWAKE), .SYNC_MASK('1)) u_wake_det (
        .clk   (clk),
        .rst   (rst),
        .raw_i (wake_in),
        .pol_i (cfg.wpol),
        .hit_o (wk_hit)
    );

    extint_edge_det #(.N(1), .SYNC_MASK(1'b1)) u_adtrg_det (
        .clk   (clk),
        .rst   (rst),
        .raw_i (adtrg_in),
        .pol_i (cfg.pol[ADTRG_SRC]),
        .hit_o (adtrg_o)
    );

    extint_flags #(.N(NSRC), .RST_VAL('0)) u_req_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (src_hit),
        .clr_we_i (bus_wr && sel == SEL_REQ1),
        .wdata_i  (bus_wdata[NSRC-1:0]),
        .flags_o  (req_flags)
    );

    extint_flags #(.N(NWAKE), .RST_VAL('0)) u_wake_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (wk_hit),
        .clr_we_i (bus_wr && sel == SEL_WREQ),
        .wdata_i  (bus_wdata[NWAKE-1:0]),
        .flags_o  (wk_flags)
    );

    always_comb begin
        case (sel)
            SEL_EDGE:  rd_val = EDGE_RSV | 8'(cfg.pol);
            SEL_EN1:   rd_val = 8'(cfg.en);
            SEL_EN2:   rd_val = 8'(cfg.wen);
            SEL_REQ1:  rd_val = REQ1_RSV | 8'(req_flags);
            SEL_REQ2:  rd_val = 8'h00;
            SEL_WREQ:  rd_val = 8'(wk_flags);
            SEL_WEDGE: rd_val = 8'(cfg.wpol);
            default:   rd_val = 8'h00;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_val : 8'h00;
    assign irq_o     = (|(req_flags & cfg.en)) | (|(wk_flags & cfg.wen));

    // R3
    rsv_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_EDGE) |-> (bus_rdata[7:5] == 3'b111));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr != A_EDGE && bus_addr != A_EN1 && bus_addr != A_EN2 &&
         bus_addr != A_REQ1 && bus_addr != A_WREQ && bus_addr != A_WEDGE)
        |-> (bus_rdata == 8'h00));

endmodule

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb_top;
    import extint_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [4:0]  src_in = '0;
    logic [7:0]  wake_in = '0;
    logic        adtrg_in = 1'b0;
    logic        adtrg_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int adcnt  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    extint_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .src_in(src_in), .wake_in(wake_in), .adtrg_in(adtrg_in),
        .adtrg_o(adtrg_o), .irq_o(irq_o)
    );

    always @(negedge clk) if (adtrg_o) adcnt++;

    // {pol, start level, end level, expected flags}
    localparam logic [19:0] VEC [5] = '{
        {5'b00000, 5'b11111, 5'b00000, 5'b11111},
        {5'b11111, 5'b00000, 5'b11111, 5'b11111},
        {5'b00000, 5'b00000, 5'b11111, 5'b00000},
        {5'b10101, 5'b00000, 5'b11111, 5'b10101},
        {5'b01100, 5'b11111, 5'b00000, 5'b10011}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic irqchk(input string req, input logic exp);
        @(negedge clk);
        #1 chk(req, {7'd0, irq_o}, {7'd0, exp});
    endtask

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        waitc(3);
        rst = 1'b0;
        waitc(2);

        // R1 reset state
        rdchk("R1 edge", A_EDGE, 8'hE0);
        rdchk("R1 en1", A_EN1, 8'h00);
        rdchk("R1 en2", A_EN2, 8'h00);
        rdchk("R1 req1", A_REQ1, 8'h20);
        rdchk("R1 req2", A_REQ2, 8'h00);
        rdchk("R1 wreq", A_WREQ, 8'h00);
        rdchk("R1 wedge", A_WEDGE, 8'h00);
        irqchk("R1 irq", 1'b0);

        // R3 reserved bits
        wr(A_EDGE, 8'h1F);
        rdchk("R3 edge all ones", A_EDGE, 8'hFF);
        wr(A_EDGE, 8'h00);
        rdchk("R3 edge rsv stay 1", A_EDGE, 8'hE0);

        // R2 vector table
        for (int v = 0; v < 5; v++) begin
            logic [4:0] pol, st, en, ex;
            {pol, st, en, ex} = VEC[v];
            wr(A_EDGE, {3'b000, pol});
            src_in = st;
            waitc(5);
            wr(A_REQ1, 8'h00);
            waitc(1);
            src_in = en;
            waitc(5);
            rdchk($sformatf("R2 vector %0d", v), A_REQ1, 8'h20 | {3'b000, ex});
        end

        // R7 polarity change on steady high levels
        src_in = 5'b11111;
        waitc(5);
        wr(A_REQ1, 8'h00);
        wr(A_EDGE, 8'h1F);
        waitc(4);
        wr(A_EDGE, 8'h00);
        waitc(4);
        rdchk("R7 no spurious flag", A_REQ1, 8'h20);

        // R6 flag set with enable off, then irq follows enable
        src_in = 5'b00000;
        waitc(5);
        wr(A_REQ1, 8'h00);
        src_in = 5'b00010;
        waitc(5);
        src_in = 5'b00000;
        waitc(5);
        rdchk("R6 flag set while disabled", A_REQ1, 8'h22);
        irqchk("R6 irq low when disabled", 1'b0);
        wr(A_EN1, 8'h02);
        irqchk("R6 irq high when enabled", 1'b1);

        // R4 writing ones keeps, writing zero clears
        wr(A_REQ1, 8'hFF);
        rdchk("R4 write ones keeps flag", A_REQ1, 8'h22);
        wr(A_REQ1, 8'hFD);
        rdchk("R4 write zero clears", A_REQ1, 8'h20);
        irqchk("R6 irq low after clear", 1'b0);
        wr(A_EN1, 8'h00);

        // R5 set wins over clear (source 0 has no synchronizer)
        wr(A_EDGE, 8'h01);
        waitc(3);
        wr(A_REQ1, 8'h00);
        @(negedge clk);
        src_in[0] = 1'b1;
        bus_addr = A_REQ1; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rdchk("R5 set beats clear", A_REQ1, 8'h21);
        wr(A_REQ1, 8'h00);
        rdchk("R4 clear after set", A_REQ1, 8'h20);
        src_in[0] = 1'b0;
        waitc(2);

        // R8 A/D trigger follows edge bit 4
        wr(A_EDGE, 8'h00);
        adtrg_in = 1'b1;
        waitc(5);
        base = adcnt;
        adtrg_in = 1'b0;
        waitc(5);
        chk("R8 falling pulse", 8'(adcnt - base), 8'd1);
        adtrg_in = 1'b1;
        waitc(5);
        chk("R8 rising ignored", 8'(adcnt - base), 8'd1);
        wr(A_EDGE, 8'h10);
        waitc(2);
        base = adcnt;
        adtrg_in = 1'b0;
        waitc(5);
        chk("R8 falling ignored", 8'(adcnt - base), 8'd0);
        adtrg_in = 1'b1;
        waitc(5);
        chk("R8 rising pulse", 8'(adcnt - base), 8'd1);
        wr(A_EDGE, 8'h00);

        // R9 wakeup path
        wr(A_WEDGE, 8'hFF);
        rdchk("R9 wedge readback", A_WEDGE, 8'hFF);
        wake_in[3] = 1'b1;
        waitc(5);
        rdchk("R9 rising sets wake flag", A_WREQ, 8'h08);
        irqchk("R6 wake irq disabled", 1'b0);
        wr(A_EN2, 8'h08);
        irqchk("R6 wake irq enabled", 1'b1);
        wr(A_WREQ, 8'hF7);
        rdchk("R4 wake flag cleared", A_WREQ, 8'h00);
        irqchk("R6 wake irq after clear", 1'b0);
        wake_in[3] = 1'b0;
        waitc(5);
        rdchk("R9 falling ignored when rising", A_WREQ, 8'h00);
        wr(A_WEDGE, 8'h00);
        wake_in[6] = 1'b1;
        waitc(5);
        wake_in[6] = 1'b0;
        waitc(5);
        rdchk("R9 falling polarity", A_WREQ, 8'h40);
        wr(A_WREQ, 8'h00);

        // R10 unmapped space
        rdchk("R10 unmapped read", 16'h1234, 8'h00);
        wr(16'hFFF5, 8'hFF);
        rdchk("R10 hole read", 16'hFFF5, 8'h00);
        rdchk("R10 en1 untouched", A_EN1, 8'h00);
        wr(A_REQ2, 8'hFF);
        rdchk("R10 req2 zero", A_REQ2, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule